// File: doc/BRIEF.md
# Compressed Radio Packet Framer

This block turns a stream of 64-bit payload beats into a complete radio transport packet. Each packet goes out on one 64-bit valid/ready stream output. With the first payload beat, the block reads a set of per-packet sideband values: the packet kind, an optional 64-bit timestamp and its request bit, the payload byte count and a 32-bit stream identifier. From these it builds a single 64-bit header line. It emits that line first, then the timestamp line if one was requested, and then passes the payload beats through unchanged.

The block keeps its own 12-bit sequence number, which it writes into every header and advances once per finished packet. The length field counts the total packet bytes, so it includes the header line and, when present, the time line. The payload input is held off while those overhead lines are produced. All output beats come from a register, and a stalled beat is held until the consumer takes it.

Top module: `rpkt_framer`

## Requirements
- R1: Header line layout: bits 63:62 packet type, bit 61 time-present flag, bit 60 burst-end/error flag, bits 59:48 sequence number, bits 47:32 total byte length, bits 31:0 the stream identifier copied from `sb_sid`.
- R2: `sb_kind` codes map to {bit63,bit62,bit60} as follows: 0 (data) gives 000, 1 (data, last of burst) gives 001, 2 (flow control) gives 010, 3 (command) gives 100, 4 (command reply) gives 110, 5 (command reply, failed) gives 111.
- R3: The undefined `sb_kind` codes 6 and 7 are framed as a failed command reply (pattern 111).
- R4: When `sb_ts_valid` is 1, the beat right after the header carries `sb_ts` and header bit 61 is 1. When it is 0, no time line is emitted and bit 61 is 0.
- R5: The length field equals `sb_payload_bytes` + 8, plus 8 more with a time line, taken modulo 2^16.
- R6: The sequence number is 0 in the first packet after reset and rises by 1 for each packet whose final beat has been accepted at the output.
- R7: The sequence number wraps from 4095 to 0.
- R8: Payload beats appear in input order after the overhead lines. `out_tlast` is 1 only on the beat carrying the last payload beat (`in_tlast`).
- R9: `in_tready` is 0 while the header and time lines are being produced, so the first payload beat is taken only after them.
- R10: While `out_tvalid` is 1 and `out_tready` is 0, `out_tdata`, `out_tlast` and `out_tvalid` stay unchanged.
- R11: A cycle with `rst` high clears `out_tvalid` and `in_tready` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_tdata | input | 64 | Payload beat |
| in_tlast | input | 1 | Marks the final payload beat |
| in_tvalid | input | 1 | Payload beat offered |
| in_tready | output | 1 | Payload beat taken |
| sb_kind | input | 3 | Packet kind code (R2, R3) |
| sb_ts_valid | input | 1 | Request a time line |
| sb_ts | input | 64 | Timestamp value |
| sb_payload_bytes | input | 16 | Payload size in bytes |
| sb_sid | input | 32 | Stream identifier |
| out_tdata | output | 64 | Packet beat |
| out_tlast | output | 1 | Final beat of the packet |
| out_tvalid | output | 1 | Packet beat offered |
| out_tready | input | 1 | Consumer accepts the beat |

## Verification
The bench sends every kind code, including the two undefined ones, and mixes packets with and without a time line. A wrong type table or a missing error fallback would show up as header bits that do not match. The time line is checked both for its position and for the overhead it adds to the length field. A payload size close to 2^16 exposes a length adder that does not wrap. Random output stalls check that stalled beats are held and that the next header is not given a stale sequence number when it is loaded in the same cycle the previous packet's final beat leaves. More than 4096 packets are run to reach the 4095-to-0 wrap, and a reset in the middle of the run must bring the sequence number back to 0.

// File: rtl/rpkt_pkg.sv
package rpkt_pkg;

  localparam int BEAT_W     = 64;
  localparam int SEQ_W      = 12;
  localparam int LEN_W      = 16;
  localparam int SID_W      = 32;
  localparam int KIND_W     = 3;
  localparam int HDR_BYTES  = BEAT_W / 8;
  localparam int TIME_BYTES = BEAT_W / 8;

  typedef enum logic [KIND_W-1:0] {
    KIND_DATA     = 3'd0,
    KIND_DATA_END = 3'd1,
    KIND_FLOW     = 3'd2,
    KIND_CMD      = 3'd3,
    KIND_REPLY    = 3'd4,
    KIND_REPLY_ER = 3'd5
  } rpkt_kind_e;

  typedef struct packed {
    logic [1:0]       ptype;
    logic             has_time;
    logic             flag;
    logic [SEQ_W-1:0] seq;
    logic [LEN_W-1:0] len;
    logic [SID_W-1:0] sid;
  } rpkt_hdr_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_TIME,
    FR_BODY
  } rpkt_fr_e;

  // returns {type[1:0], flag}; unknown codes fall back to a failed reply
  function automatic logic [2:0] kind_code(input logic [KIND_W-1:0] k);
    case (k)
      KIND_DATA:     kind_code = 3'b000;
      KIND_DATA_END: kind_code = 3'b001;
      KIND_FLOW:     kind_code = 3'b010;
      KIND_CMD:      kind_code = 3'b100;
      KIND_REPLY:    kind_code = 3'b110;
      default:       kind_code = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/rpkt_seq_ctr.sv
module rpkt_seq_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] seq_ahead
);

  logic [W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (rst) seq_q <= '0;
    else if (advance) seq_q <= seq_q + W'(1);
  end

  // value seen by a header loaded in the same cycle a packet completes
  assign seq_ahead = advance ? seq_q + W'(1) : seq_q;

endmodule

// File: rtl/rpkt_hdr_pack.sv
module rpkt_hdr_pack
  import rpkt_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              has_time,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [LEN_W-1:0]  payload_bytes,
  input  logic [SID_W-1:0]  sid,
  output logic [BEAT_W-1:0] hdr_o
);

  localparam logic [LEN_W-1:0] HDR_ADD  = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] TIME_ADD = LEN_W'(TIME_BYTES);

  rpkt_hdr_t  hdr;
  logic [2:0] code;

  always_comb begin
    code         = kind_code(kind);
    hdr.ptype    = code[2:1];
    hdr.flag     = code[0];
    hdr.has_time = has_time;
    hdr.seq      = seq;
    hdr.len      = payload_bytes + HDR_ADD + (has_time ? TIME_ADD : '0);
    hdr.sid      = sid;
  end

  assign hdr_o = hdr;

endmodule

// File: rtl/rpkt_beat_reg.sv
module rpkt_beat_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         ld_last,
  input  logic         take,
  output logic [W-1:0] q_data,
  output logic         q_last,
  output logic         q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (take) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_data <= ld_data;
      q_last <= ld_last;
    end
  end

endmodule

// File: rtl/rpkt_framer.sv
module rpkt_framer
  import rpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BEAT_W-1:0] in_tdata,
  input  logic              in_tlast,
  input  logic              in_tvalid,
  output logic              in_tready,
  input  logic [KIND_W-1:0] sb_kind,
  input  logic              sb_ts_valid,
  input  logic [BEAT_W-1:0] sb_ts,
  input  logic [LEN_W-1:0]  sb_payload_bytes,
  input  logic [SID_W-1:0]  sb_sid,
  output logic [BEAT_W-1:0] out_tdata,
  output logic              out_tlast,
  output logic              out_tvalid,
  input  logic              out_tready
);

  rpkt_fr_e          st, st_nxt;
  logic              load_ok, load, ld_last, cap_time, pkt_done;
  logic [BEAT_W-1:0] ld_data, hdr_w, ts_q;
  logic [SEQ_W-1:0]  seq_now;

  assign load_ok  = !out_tvalid || out_tready;
  assign pkt_done = out_tvalid && out_tready && out_tlast;

  rpkt_seq_ctr #(.W(SEQ_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .advance   (pkt_done),
    .seq_ahead (seq_now)
  );

  rpkt_hdr_pack u_hdr (
    .kind          (sb_kind),
    .has_time      (sb_ts_valid),
    .seq           (seq_now),
    .payload_bytes (sb_payload_bytes),
    .sid           (sb_sid),
    .hdr_o         (hdr_w)
  );

  always_comb begin
    st_nxt    = st;
    load      = 1'b0;
    ld_data   = hdr_w;
    ld_last   = 1'b0;
    in_tready = 1'b0;
    cap_time  = 1'b0;
    case (st)
      FR_IDLE: begin
        if (in_tvalid && load_ok) begin
          load     = 1'b1;
          cap_time = 1'b1;
          st_nxt   = sb_ts_valid ? FR_TIME : FR_BODY;
        end
      end
      FR_TIME: begin
        if (load_ok) begin
          load    = 1'b1;
          ld_data = ts_q;
          st_nxt  = FR_BODY;
        end
      end
      FR_BODY: begin
        in_tready = load_ok;
        if (in_tvalid && load_ok) begin
          load    = 1'b1;
          ld_data = in_tdata;
          ld_last = in_tlast;
          if (in_tlast) st_nxt = FR_IDLE;
        end
      end
      default: st_nxt = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= FR_IDLE;
    else st <= st_nxt;
  end

  always_ff @(posedge clk) begin
    if (cap_time) ts_q <= sb_ts;
  end

  rpkt_beat_reg #(.W(BEAT_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ld_data (ld_data),
    .ld_last (ld_last),
    .take    (out_tready),
    .q_data  (out_tdata),
    .q_last  (out_tlast),
    .q_valid (out_tvalid)
  );

endmodule

// File: rtl/rpkt_framer_chk.sv
module rpkt_framer_chk
  import rpkt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_tready,
  input logic [KIND_W-1:0] sb_kind,
  input logic              sb_ts_valid,
  input logic [LEN_W-1:0]  sb_payload_bytes,
  input logic [SID_W-1:0]  sb_sid,
  input logic [BEAT_W-1:0] out_tdata,
  input logic              out_tlast,
  input logic              out_tvalid,
  input logic              out_tready
);

  logic             at_hdr;
  logic [SEQ_W-1:0] seq_m;
  logic             hdr_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_hdr <= 1'b1;
      seq_m  <= '0;
    end else if (out_tvalid && out_tready) begin
      at_hdr <= out_tlast;
      if (out_tlast) seq_m <= seq_m + SEQ_W'(1);
    end
  end

  assign hdr_beat = out_tvalid && at_hdr;

  p_sid_r1: assert property (@(posedge clk) disable iff (rst)
    hdr_beat |-> out_tdata[31:0] == sb_sid);

  p_legal_type_r2: assert property (@(posedge clk) disable iff (rst)
    hdr_beat |-> ({out_tdata[63:62], out_tdata[60]} != 3'b011 &&
                  {out_tdata[63:62], out_tdata[60]} != 3'b101));

  p_unknown_kind_r3: assert property (@(posedge clk) disable iff (rst)
    (hdr_beat && sb_kind > KIND_W'(5)) |-> {out_tdata[63:62], out_tdata[60]} == 3'b111);

  p_time_flag_r4: assert property (@(posedge clk) disable iff (rst)
    hdr_beat |-> out_tdata[61] == sb_ts_valid);

  p_length_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_beat |-> out_tdata[47:32] ==
      LEN_W'(sb_payload_bytes + LEN_W'(8) + (sb_ts_valid ? LEN_W'(8) : LEN_W'(0))));

  p_seq_r6: assert property (@(posedge clk) disable iff (rst)
    hdr_beat |-> out_tdata[59:48] == seq_m);

  p_in_hold_r9: assert property (@(posedge clk) disable iff (rst)
    in_tready |-> (!out_tvalid || out_tready));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!out_tvalid && !in_tready));

endmodule

bind rpkt_framer rpkt_framer_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .in_tready        (in_tready),
  .sb_kind          (sb_kind),
  .sb_ts_valid      (sb_ts_valid),
  .sb_payload_bytes (sb_payload_bytes),
  .sb_sid           (sb_sid),
  .out_tdata        (out_tdata),
  .out_tlast        (out_tlast),
  .out_tvalid       (out_tvalid),
  .out_tready       (out_tready)
);

// File: tb/rpkt_framer_bench.sv
`timescale 1ns/1ps
module rpkt_framer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_tdata = '0;
  logic        in_tlast = 1'b0;
  logic        in_tvalid = 1'b0;
  logic        in_tready;
  logic [2:0]  sb_kind = '0;
  logic        sb_ts_valid = 1'b0;
  logic [63:0] sb_ts = '0;
  logic [15:0] sb_payload_bytes = '0;
  logic [31:0] sb_sid = '0;
  logic [63:0] out_tdata;
  logic        out_tlast;
  logic        out_tvalid;
  logic        out_tready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit bp_en = 1'b0;
  logic [11:0] exp_seq = '0;

  logic [63:0] cap_d [16];
  logic        cap_l [16];
  int          cap_cnt = 0;

  always #2.5 clk = ~clk;

  rpkt_framer u_rpkt_framer (
    .clk(clk), .rst(rst),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .sb_kind(sb_kind), .sb_ts_valid(sb_ts_valid), .sb_ts(sb_ts),
    .sb_payload_bytes(sb_payload_bytes), .sb_sid(sb_sid),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tvalid(out_tvalid), .out_tready(out_tready)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic        tsv;
    logic [3:0]  nb;
    logic [15:0] bytes;
    logic [31:0] sid;
    logic        bp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{3'd0, 1'b0, 4'd2, 16'd16,     32'h0001_0002, 1'b0},
    '{3'd1, 1'b1, 4'd1, 16'd8,      32'hDEAD_BEEF, 1'b0},
    '{3'd2, 1'b0, 4'd1, 16'd4,      32'h1234_5678, 1'b1},
    '{3'd3, 1'b1, 4'd3, 16'd24,     32'hA0B0_C0D0, 1'b1},
    '{3'd4, 1'b0, 4'd2, 16'd12,     32'h0000_0001, 1'b0},
    '{3'd5, 1'b1, 4'd1, 16'd8,      32'hFFFF_FFFF, 1'b1},
    '{3'd6, 1'b0, 4'd1, 16'd8,      32'h55AA_55AA, 1'b0},
    '{3'd7, 1'b1, 4'd4, 16'd32,     32'h0F0F_0F0F, 1'b1},
    '{3'd0, 1'b0, 4'd1, 16'hFFF8,   32'h7777_0000, 1'b0}
  };

  // backpressure source
  initial begin
    logic [7:0] lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_tready = bp_en ? lfsr[0] : 1'b1;
    end
  end

  // output monitor, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (out_tvalid && out_tready && cap_cnt < 16) begin
        cap_d[cap_cnt] = out_tdata;
        cap_l[cap_cnt] = out_tlast;
        cap_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_hdr(input logic [2:0] kind, input logic tsv,
                                          input logic [11:0] seq, input logic [15:0] bytes,
                                          input logic [31:0] sid);
    logic [2:0]  pat;
    logic [15:0] len;
    case (kind)
      3'd0: pat = 3'b000;
      3'd1: pat = 3'b001;
      3'd2: pat = 3'b010;
      3'd3: pat = 3'b100;
      3'd4: pat = 3'b110;
      default: pat = 3'b111;
    endcase
    len = bytes + 16'd8 + (tsv ? 16'd8 : 16'd0);
    return {pat[2:1], tsv, pat[0], seq, len, sid};
  endfunction

  function automatic logic [63:0] pay(input int pid, input int b);
    return 64'hC0DE_0000_0000_0000 | (64'(pid) << 8) | 64'(b);
  endfunction

  task automatic run_pkt(input int pid, input logic [2:0] kind, input logic tsv, input int nb,
                         input logic [15:0] bytes, input logic [31:0] sid, input logic bp);
    logic [63:0] tsval;
    int first_wait;
    int w;
    int total;
    tsval = 64'h0123_4567_89AB_0000 | 64'(pid & 16'hFFFF);
    total = 1 + int'(tsv) + nb;
    first_wait = 0;
    @(negedge clk);
    bp_en = bp;
    @(negedge clk);
    cap_cnt = 0;
    sb_kind = kind; sb_ts_valid = tsv; sb_ts = tsval;
    sb_payload_bytes = bytes; sb_sid = sid;
    for (int b = 0; b < nb; b++) begin
      if (b > 0) @(negedge clk);
      in_tvalid = 1'b1;
      in_tdata  = pay(pid, b);
      in_tlast  = (b == nb - 1);
      #1;
      w = 0;
      while (!in_tready) begin
        @(negedge clk);
        #1;
        w++;
      end
      if (b == 0) first_wait = w;
    end
    @(negedge clk);
    in_tvalid = 1'b0;
    in_tlast  = 1'b0;
    w = 0;
    while (cap_cnt < total && w < 200) begin
      @(negedge clk);
      #2;
      w++;
    end
    chk("R8 beat count", 64'(cap_cnt), 64'(total));
    if (kind > 3'd5) chk("R3 header", cap_d[0], exp_hdr(kind, tsv, exp_seq, bytes, sid));
    else             chk("R2 header", cap_d[0], exp_hdr(kind, tsv, exp_seq, bytes, sid));
    chk("R1 sid field", 64'(cap_d[0][31:0]), 64'(sid));
    chk("R5 length", 64'(cap_d[0][47:32]), 64'(16'(bytes + 16'd8 + (tsv ? 16'd8 : 16'd0))));
    chk("R6 seq", 64'(cap_d[0][59:48]), 64'(exp_seq));
    if (exp_seq == 12'd0) chk("R7 seq wrap to zero", 64'(cap_d[0][59:48]), 64'd0);
    chk("R4 time flag", 64'(cap_d[0][61]), 64'(tsv));
    chk("R8 header not last", 64'(cap_l[0]), 64'd0);
    if (tsv) begin
      chk("R4 time line", cap_d[1], tsval);
      chk("R8 time not last", 64'(cap_l[1]), 64'd0);
    end
    for (int b = 0; b < nb; b++) begin
      if (bp) chk("R10 payload under stall", cap_d[1 + int'(tsv) + b], pay(pid, b));
      else    chk("R8 payload", cap_d[1 + int'(tsv) + b], pay(pid, b));
      chk("R8 last marker", 64'(cap_l[1 + int'(tsv) + b]), 64'(b == nb - 1));
    end
    if (!bp) chk("R9 payload held during overhead", 64'(first_wait), 64'(1 + int'(tsv)));
    exp_seq = exp_seq + 12'd1;
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R11 reset out_tvalid", 64'(out_tvalid), 64'd0);
    chk("R11 reset in_tready", 64'(in_tready), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 9; i++)
      run_pkt(i, VEC[i].kind, VEC[i].tsv, int'(VEC[i].nb), VEC[i].bytes, VEC[i].sid, VEC[i].bp);

    // run through the 4095 -> 0 wrap
    while (exp_seq != 12'd1)
      run_pkt(100, 3'd0, 1'b0, 1, 16'd8, 32'hCAFE_0000, 1'b0);

    // reset mid-run: sequence restarts at zero
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 mid-run reset out_tvalid", 64'(out_tvalid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    exp_seq = '0;
    run_pkt(200, 3'd4, 1'b1, 2, 16'd16, 32'hBEEF_0001, 1'b0);
    run_pkt(201, 3'd1, 1'b0, 3, 16'd20, 32'hBEEF_0002, 1'b1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule